// File: doc/BRIEF.md
# Dual-Path Latching Bus Transceiver

This block passes a parameterized data word between two ports, A and B, in both directions. Each direction has its own holding element that works either as a see-through latch or as a register loaded on the rising edge of that direction's strobe clock. The holding mode is picked by the direction's latch enable: while it is high the output tracks the input in the same cycle, and while it is low the output shows the stored word, which is reloaded only when a strobe rising edge is seen. The two directions use enables of opposite sense: the A-to-B enable is active high, the B-to-A enable is active low.

Each port has separate input, input-drive mask, output and output-enable signals, so no tri-state logic exists inside the block; a wrapper may merge them onto bidirectional pins. Each input bit has a keeper. An undriven bit (drive mask 0) shows the value it had on the last clock, so an unknown or floating value never reaches the holding element. Strobe clocks and latch enables are sampled by the system clock `clk`. A strobe rising edge is a 0 on one `clk` edge followed by a 1 on the next, and the load happens on the second of those edges.

Top module: `xcvr_universal`

## Requirements
- R1: A synchronous active-high reset clears both holding elements and both keepers to all zeros. After reset, with latch enables low and inputs undriven, both data outputs read 0.
- R2: While `ab_le` is 1, `b_out` equals the effective A word in the same cycle, with no clock edge in between.
- R3: While `ab_le` is 0 and no rising strobe edge is sampled on `ab_clk`, `b_out` holds its value even when A changes.
- R4: While `ab_le` is 0, a rising edge on `ab_clk` (sampled 0 then 1 on two consecutive `clk` edges) loads the effective A word present at the second edge. `b_out` shows that word from then on.
- R5: When `ab_le` falls, `b_out` keeps the word that was present at the last `clk` edge while `ab_le` was still high.
- R6: `b_oe` is 1 exactly when `ab_oe` is 1 (active high).
- R7: `a_oe` is 1 exactly when `ba_oe_n` is 0 (active low).
- R8: The B-to-A path behaves like R2 to R5, using `ba_le`, `ba_clk`, `b_in` and `a_out`.
- R9: Each input bit whose drive-mask bit is 0 takes the value that bit had at the previous `clk` edge. Bits whose mask bit is 1 take the input value.
- R10: A strobe load taken while bits are undriven stores the keeper values of those bits.
- R11: A strobe edge seen while the latch enable is high has no extra effect: the output still follows the input.
- R12: A falling strobe edge does not load the holding element.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | W | Values seen on the A port |
| a_drv | input | W | Per-bit mask, 1 where the A port is driven |
| b_in | input | W | Values seen on the B port |
| b_drv | input | W | Per-bit mask, 1 where the B port is driven |
| ab_le | input | 1 | A-to-B latch enable, 1 selects see-through mode |
| ab_clk | input | 1 | A-to-B load strobe, acts on its rising edge |
| ab_oe | input | 1 | A-to-B output enable, active high |
| ba_le | input | 1 | B-to-A latch enable, 1 selects see-through mode |
| ba_clk | input | 1 | B-to-A load strobe, acts on its rising edge |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| a_out | output | W | Data driven toward the A port |
| a_oe | output | 1 | Drive enable for the A port |
| b_out | output | W | Data driven toward the B port |
| b_oe | output | 1 | Drive enable for the B port |

## Verification
A wrong stored word cannot be seen while its latch enable is high. It shows on the data output in the first cycle after the enable goes low, and it stays there until the next strobe load. A keeper that lost its value shows one cycle after the mask drops, and only in see-through mode. A falsely detected strobe edge shows on the next cycle of a held output. For this reason the bench checks every hold, both before and after each strobe transition.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  typedef enum logic [1:0] {
    HOLD_KEEP    = 2'd0,
    HOLD_FOLLOW  = 2'd1,
    HOLD_STROBE  = 2'd2
  } hold_act_e;

  function automatic hold_act_e pick_act(input logic le, input logic rise);
    if (le)        return HOLD_FOLLOW;
    else if (rise) return HOLD_STROBE;
    else           return HOLD_KEEP;
  endfunction

endpackage

// File: rtl/xcvr_keeper.sv
module xcvr_keeper #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pin,
  input  logic [W-1:0] drv,
  output logic [W-1:0] eff
);
  logic [W-1:0] held;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign eff[i] = drv[i] ? pin[i] : held[i];
    always_ff @(posedge clk) begin
      if (rst) held[i] <= 1'b0;
      else     held[i] <= eff[i];
    end
  end
endmodule

// File: rtl/xcvr_path.sv
module xcvr_path
  import xcvr_pkg::*;
#(
  parameter int W       = 18,
  parameter bit OE_LOW  = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         le,
  input  logic         strobe,
  input  logic         oe_in,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic         oe
);
  logic         strobe_q;
  logic         rise;
  logic [W-1:0] store;
  hold_act_e    act;

  assign rise = strobe & ~strobe_q;
  assign act  = pick_act(le, rise);

  always_ff @(posedge clk) begin
    if (rst) strobe_q <= strobe;
    else     strobe_q <= strobe;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      store <= '0;
    end else begin
      case (act)
        HOLD_FOLLOW, HOLD_STROBE: store <= d;
        default:                  store <= store;
      endcase
    end
  end

  assign q = (act == HOLD_FOLLOW) ? d : store;

  if (OE_LOW) begin : g_oe_low
    assign oe = ~oe_in;
  end else begin : g_oe_high
    assign oe = oe_in;
  end
endmodule

// File: rtl/xcvr_universal.sv
module xcvr_universal #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] a_drv,
  input  logic [W-1:0] b_in,
  input  logic [W-1:0] b_drv,
  input  logic         ab_le,
  input  logic         ab_clk,
  input  logic         ab_oe,
  input  logic         ba_le,
  input  logic         ba_clk,
  input  logic         ba_oe_n,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  output logic [W-1:0] b_out,
  output logic         b_oe
);
  logic [W-1:0] a_eff;
  logic [W-1:0] b_eff;

  xcvr_keeper #(.W(W)) u_keep_a (.clk(clk), .rst(rst), .pin(a_in), .drv(a_drv), .eff(a_eff));
  xcvr_keeper #(.W(W)) u_keep_b (.clk(clk), .rst(rst), .pin(b_in), .drv(b_drv), .eff(b_eff));

  xcvr_path #(.W(W), .OE_LOW(1'b0)) u_ab (
    .clk(clk), .rst(rst), .le(ab_le), .strobe(ab_clk), .oe_in(ab_oe),
    .d(a_eff), .q(b_out), .oe(b_oe)
  );

  xcvr_path #(.W(W), .OE_LOW(1'b1)) u_ba (
    .clk(clk), .rst(rst), .le(ba_le), .strobe(ba_clk), .oe_in(ba_oe_n),
    .d(b_eff), .q(a_out), .oe(a_oe)
  );
endmodule

// File: rtl/xcvr_universal_chk.sv
module xcvr_universal_chk #(
  parameter int W = 18
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] a_eff,
  input logic [W-1:0] b_eff,
  input logic [W-1:0] a_drv,
  input logic [W-1:0] b_drv,
  input logic         ab_le,
  input logic         ab_clk,
  input logic         ba_le,
  input logic         ba_clk,
  input logic [W-1:0] a_out,
  input logic [W-1:0] b_out
);
  AST_AB_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!ab_le && !$rose(ab_clk)) |=> (ab_le || $stable(b_out))); // R3

  AST_AB_LOAD: assert property (@(posedge clk) disable iff (rst)
    (!ab_le && $rose(ab_clk)) |=> (ab_le || b_out == $past(a_eff))); // R4

  AST_AB_LEFALL: assert property (@(posedge clk) disable iff (rst)
    ($fell(ab_le) && !$past(rst)) |-> (b_out == $past(a_eff))); // R5

  AST_BA_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!ba_le && !$rose(ba_clk)) |=> (ba_le || $stable(a_out))); // R8

  AST_BA_LOAD: assert property (@(posedge clk) disable iff (rst)
    (!ba_le && $rose(ba_clk)) |=> (ba_le || a_out == $past(b_eff))); // R8

  AST_A_KEEP: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (((a_eff ^ $past(a_eff)) & ~a_drv) == '0)); // R9

  AST_B_KEEP: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (((b_eff ^ $past(b_eff)) & ~b_drv) == '0)); // R9
endmodule

bind xcvr_universal xcvr_universal_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .a_eff(a_eff), .b_eff(b_eff), .a_drv(a_drv), .b_drv(b_drv),
  .ab_le(ab_le), .ab_clk(ab_clk), .ba_le(ba_le), .ba_clk(ba_clk),
  .a_out(a_out), .b_out(b_out)
);

// File: tb/sim_xcvr_universal.sv
module sim_xcvr_universal;
  localparam int W = 18;
  localparam logic [W-1:0] ALL = '1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] a_in = '0, a_drv = ALL, b_in = '0, b_drv = ALL;
  logic ab_le = 1'b0, ab_clk = 1'b0, ab_oe = 1'b0;
  logic ba_le = 1'b0, ba_clk = 1'b0, ba_oe_n = 1'b1;
  logic [W-1:0] a_out, b_out;
  logic a_oe, b_oe;

  always #4 clk = ~clk;

  xcvr_universal #(.W(W)) u0 (
    .clk(clk), .rst(rst), .a_in(a_in), .a_drv(a_drv), .b_in(b_in), .b_drv(b_drv),
    .ab_le(ab_le), .ab_clk(ab_clk), .ab_oe(ab_oe), .ba_le(ba_le), .ba_clk(ba_clk),
    .ba_oe_n(ba_oe_n), .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe)
  );

  typedef struct {
    int           sel;
    logic [W-1:0] val;
    string        req;
  } exp_t;

  exp_t q[$];
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  bit summary_out = 1'b0;

  task automatic push(input int sel, input logic [W-1:0] val, input string req);
    exp_t e;
    e.sel = sel; e.val = val; e.req = req;
    q.push_back(e);
  endtask

  task automatic exp_b(input logic [W-1:0] v, input string r); push(0, v, r); endtask
  task automatic exp_a(input logic [W-1:0] v, input string r); push(1, v, r); endtask
  task automatic exp_boe(input logic v, input string r); push(2, {{(W-1){1'b0}}, v}, r); endtask
  task automatic exp_aoe(input logic v, input string r); push(3, {{(W-1){1'b0}}, v}, r); endtask

  task automatic step();
    @(negedge clk);
  endtask

  // monitor: compares queued expectations 2 ns after each input change
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (q.size() > 0) begin
        exp_t e;
        logic [W-1:0] got;
        e = q.pop_front();
        case (e.sel)
          0: got = b_out;
          1: got = a_out;
          2: got = {{(W-1){1'b0}}, b_oe};
          default: got = {{(W-1){1'b0}}, a_oe};
        endcase
        n_chk++;
        if (got !== e.val) begin
          n_bad++;
          $display("FAIL %s sel=%0d actual=%h expected=%h", e.req, e.sel, got, e.val);
        end
      end
    end
  end

  task automatic finish_run();
    if (!summary_out) begin
      summary_out = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    repeat (3) step();
    rst = 1'b0;
    // R1: reset state
    a_drv = '0; b_drv = '0; a_in = 18'h3FFFF; b_in = 18'h3FFFF;
    exp_b('0, "R1"); exp_a('0, "R1");
    exp_boe(1'b0, "R6"); exp_aoe(1'b0, "R7");
    step();
    ab_le = 1'b1; ba_le = 1'b1;
    exp_b('0, "R1 keeper"); exp_a('0, "R1 keeper");
    // R6, R7 enables
    step();
    ab_oe = 1'b1; ba_oe_n = 1'b0;
    exp_boe(1'b1, "R6"); exp_aoe(1'b1, "R7");
    // R2 transparent
    step();
    a_drv = ALL; a_in = 18'h2A5A5;
    exp_b(18'h2A5A5, "R2");
    step();
    a_in = 18'h15A5A;
    exp_b(18'h15A5A, "R2");
    // R5 latch enable fall
    step();
    ab_le = 1'b0;
    exp_b(18'h15A5A, "R5");
    // R3 hold while A changes
    step();
    a_in = 18'h3FFFF;
    exp_b(18'h15A5A, "R3");
    step();
    a_in = 18'h00F00;
    exp_b(18'h15A5A, "R3");
    // R4 rising strobe
    step();
    a_in = 18'h3FFFF; ab_clk = 1'b1;
    exp_b(18'h15A5A, "R4 before edge");
    step();
    a_in = 18'h00001;
    exp_b(18'h3FFFF, "R4");
    step();
    exp_b(18'h3FFFF, "R3 strobe held high");
    // R12 falling strobe
    step();
    ab_clk = 1'b0; a_in = 18'h00002;
    exp_b(18'h3FFFF, "R12");
    step();
    a_in = 18'h00003;
    exp_b(18'h3FFFF, "R12");
    // R11 strobe in transparent mode
    step();
    ab_le = 1'b1; ab_clk = 1'b1; a_in = 18'h12345;
    exp_b(18'h12345, "R11");
    step();
    a_in = 18'h0ABCD;
    exp_b(18'h0ABCD, "R11");
    step();
    ab_clk = 1'b0; a_in = 18'h2AAAA;
    exp_b(18'h2AAAA, "R11");
    // R9 keeper partial
    step();
    a_drv = 18'h000FF; a_in = 18'h00000;
    exp_b(18'h2AA00, "R9");
    step();
    a_drv = '0; a_in = 18'h3FFFF;
    exp_b(18'h2AA00, "R9");
    // R10 capture of keeper values
    step();
    ab_le = 1'b0;
    exp_b(18'h2AA00, "R10 le fall");
    step();
    ab_clk = 1'b1;
    step();
    a_drv = ALL; a_in = 18'h11111;
    exp_b(18'h2AA00, "R10");
    step();
    ab_clk = 1'b0;
    // R8 B-to-A
    step();
    b_drv = ALL; b_in = 18'h1F0F0;
    exp_a(18'h1F0F0, "R8 transparent");
    step();
    ba_le = 1'b0; b_in = 18'h00F0F;
    exp_a(18'h1F0F0, "R8 le fall");
    step();
    ba_clk = 1'b1;
    exp_a(18'h1F0F0, "R8 before edge");
    step();
    b_in = 18'h33333;
    exp_a(18'h00F0F, "R8 load");
    step();
    ba_clk = 1'b0;
    exp_a(18'h00F0F, "R8 hold");
    step();
    b_drv = '0; b_in = '0;
    exp_a(18'h00F0F, "R8 hold");
    // R9 B keeper then R10 capture
    step();
    ba_clk = 1'b1;
    step();
    exp_a(18'h33333, "R10 b keeper load");
    // output enables off again
    ab_oe = 1'b0; ba_oe_n = 1'b1;
    exp_boe(1'b0, "R6"); exp_aoe(1'b0, "R7");
    step();
    step();
    done = 1'b1;
    finish_run();
  end
endmodule